// File: doc/BRIEF.md
# Digital IQ Vector Modulator

This block turns a pair of signed baseband words, an in-phase word and a quadrature word, into a stream of intermediate-frequency samples for a digital-to-analogue converter. A numerically controlled phase accumulator advances by a programmable step on every clock. Its upper bits address two computed waveform tables, one holding cosine and one holding sine. The in-phase word is scaled by the cosine sample and the quadrature word by the sine sample. The two products are summed, rounded and clamped into a signed 16-bit converter code.

The amplitude of the resulting carrier follows sqrt(I²+Q²) and its phase follows arctan(Q/I). Control logic can therefore steer both gain and phase by writing the vector alone, with no analogue mixer in the path. The pipeline has a fixed depth, and a valid flag travels beside the data so that the consumer knows which samples carry a qualified vector.

Top module: `iq_vecmod`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, clears the phase accumulator and every pipeline register. After reset `dac_code` is 0 and `dac_valid` is 0 until new samples have travelled the pipeline.
- R2: The 32-bit phase accumulator starts at 0 and adds `phase_step` on every rising edge, modulo 2^32, whether or not `in_valid` is high. The sample taken at an edge uses the accumulator value held before that edge, and its bits [31:22] form the table index k.
- R3: Entry k of the cosine table is round(32767·cos(2πk/1024)) and entry k of the sine table is round(32767·sin(2πk/1024)), where k runs from 0 to 1023 and both are signed 16-bit values.
- R4: For signed 16-bit inputs I and Q, the unclamped result is floor((I·cos[k] + Q·sin[k] + 16384) / 32768). This is a round-half-up scaling by 2^-15.
- R5: The result is clamped to the range -32768 to 32767 and never wraps. When |I| and |Q| are both at most 8191, the output never reaches either limit.
- R6: When I = Q = 0 the output code is exactly 0, at any phase.
- R7: The latency is fixed at 4 clocks: inputs sampled at edge e appear on `dac_code` after edge e+3. `dac_valid` equals `in_valid` delayed by the same 4 clocks.
- R8: A new `phase_step` takes effect at the next edge. The index sequence then follows the new step from the accumulator value already reached, with no phase jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| i_word | input | 16 | Signed in-phase baseband word |
| q_word | input | 16 | Signed quadrature baseband word |
| phase_step | input | 32 | Unsigned phase increment per clock |
| in_valid | input | 1 | Qualifies the I/Q pair |
| dac_code | output | 16 | Signed registered converter code |
| dac_valid | output | 1 | `in_valid` delayed by 4 clocks |

## Verification
Clamping and a change of phase step can fall in the same clock. A full-scale vector can be clamping while the accumulator wraps past 2^32 on a step that has just been switched to a near-negative value. The bench provokes this by driving I = Q = 32767 and, in the same cycle, replacing a small step with 0xFFC00000 or a step that straddles the wrap. A behavioural model, which keeps its own accumulator, its own tables computed from the cosine and sine formulas, and a 4-deep queue, predicts the code and the valid flag on every clock, so a wrong index or a wrapped sum in that cycle shows up as a mismatch.

// File: rtl/iqm_pkg.sv
package iqm_pkg;

    typedef enum logic {
        TBL_SIN = 1'b0,
        TBL_COS = 1'b1
    } trig_kind_e;

    localparam real TWO_PI = 6.283185307179586;

endpackage

// File: rtl/iqm_phase_acc.sv
module iqm_phase_acc #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] step,
    output logic [ADDR_W-1:0]  addr
);
    logic [PHASE_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            addr  <= '0;
        end else begin
            addr  <= acc_q[PHASE_W-1 -: ADDR_W];
            acc_q <= acc_q + step;
        end
    end
endmodule

// File: rtl/iqm_trig_rom.sv
module iqm_trig_rom
    import iqm_pkg::*;
#(
    parameter int         ADDR_W = 10,
    parameter int         DATA_W = 16,
    parameter trig_kind_e KIND   = TBL_COS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [DATA_W-1:0] data
);
    localparam int  DEPTH = 1 << ADDR_W;
    localparam real AMP   = real'((1 << (DATA_W - 1)) - 1);

    logic signed [DATA_W-1:0] tbl [DEPTH];

    generate
        if (KIND == TBL_COS) begin : g_cos
            initial begin
                for (int k = 0; k < DEPTH; k++) begin
                    tbl[k] = DATA_W'(int'(AMP * $cos(TWO_PI * real'(k) / real'(DEPTH))));
                end
            end
        end else begin : g_sin
            initial begin
                for (int k = 0; k < DEPTH; k++) begin
                    tbl[k] = DATA_W'(int'(AMP * $sin(TWO_PI * real'(k) / real'(DEPTH))));
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) data <= '0;
        else     data <= tbl[addr];
    end
endmodule

// File: rtl/iqm_prod.sv
module iqm_prod #(
    parameter int IN_W  = 16,
    parameter int TBL_W = 16,
    localparam int PROD_W = IN_W + TBL_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [IN_W-1:0]   i_val,
    input  logic signed [IN_W-1:0]   q_val,
    input  logic signed [TBL_W-1:0]  cos_val,
    input  logic signed [TBL_W-1:0]  sin_val,
    output logic signed [PROD_W-1:0] i_prod,
    output logic signed [PROD_W-1:0] q_prod
);
    always_ff @(posedge clk) begin
        if (rst) begin
            i_prod <= '0;
            q_prod <= '0;
        end else begin
            i_prod <= PROD_W'(i_val) * PROD_W'(cos_val);
            q_prod <= PROD_W'(q_val) * PROD_W'(sin_val);
        end
    end
endmodule

// File: rtl/iqm_round_sat.sv
module iqm_round_sat #(
    parameter int PROD_W = 32,
    parameter int FRAC   = 15,
    parameter int OUT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [PROD_W-1:0] a,
    input  logic signed [PROD_W-1:0] b,
    output logic signed [OUT_W-1:0]  y
);
    localparam int WIDE = PROD_W + 2;
    localparam logic signed [WIDE-1:0] HALF = WIDE'(1) <<< (FRAC - 1);
    localparam logic signed [WIDE-1:0] MAXV = (WIDE'(1) <<< (OUT_W - 1)) - WIDE'(1);
    localparam logic signed [WIDE-1:0] MINV = -(WIDE'(1) <<< (OUT_W - 1));

    logic signed [WIDE-1:0] total;
    logic signed [WIDE-1:0] scaled;
    logic signed [OUT_W-1:0] clamped;

    always_comb begin
        total  = WIDE'(a) + WIDE'(b) + HALF;
        scaled = total >>> FRAC;
        if (scaled > MAXV)      clamped = MAXV[OUT_W-1:0];
        else if (scaled < MINV) clamped = MINV[OUT_W-1:0];
        else                    clamped = scaled[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) y <= '0;
        else     y <= clamped;
    end
endmodule

// File: rtl/iq_vecmod.sv
module iq_vecmod
    import iqm_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int IN_W    = 16,
    parameter int TBL_W   = 16,
    parameter int OUT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [IN_W-1:0]  i_word,
    input  logic signed [IN_W-1:0]  q_word,
    input  logic [PHASE_W-1:0]      phase_step,
    input  logic                    in_valid,
    output logic signed [OUT_W-1:0] dac_code,
    output logic                    dac_valid
);
    localparam int PROD_W = IN_W + TBL_W;
    localparam int FRAC   = TBL_W - 1;
    localparam int LAT    = 4;

    logic [ADDR_W-1:0]        idx;
    logic signed [TBL_W-1:0]  cos_s, sin_s;
    logic signed [IN_W-1:0]   i_d1, q_d1, i_d2, q_d2;
    logic signed [PROD_W-1:0] i_prod, q_prod;
    logic [LAT-1:0]           vld_sr;

    // stage 1: index capture and accumulator advance
    iqm_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
        .clk(clk), .rst(rst), .step(phase_step), .addr(idx)
    );

    // stage 2: table reads
    iqm_trig_rom #(.ADDR_W(ADDR_W), .DATA_W(TBL_W), .KIND(TBL_COS)) u_cos (
        .clk(clk), .rst(rst), .addr(idx), .data(cos_s)
    );
    iqm_trig_rom #(.ADDR_W(ADDR_W), .DATA_W(TBL_W), .KIND(TBL_SIN)) u_sin (
        .clk(clk), .rst(rst), .addr(idx), .data(sin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            i_d1   <= '0;
            q_d1   <= '0;
            i_d2   <= '0;
            q_d2   <= '0;
            vld_sr <= '0;
        end else begin
            i_d1   <= i_word;
            q_d1   <= q_word;
            i_d2   <= i_d1;
            q_d2   <= q_d1;
            vld_sr <= {vld_sr[LAT-2:0], in_valid};
        end
    end

    // stage 3: products
    iqm_prod #(.IN_W(IN_W), .TBL_W(TBL_W)) u_prod (
        .clk(clk), .rst(rst),
        .i_val(i_d2), .q_val(q_d2), .cos_val(cos_s), .sin_val(sin_s),
        .i_prod(i_prod), .q_prod(q_prod)
    );

    // stage 4: sum, round, clamp
    iqm_round_sat #(.PROD_W(PROD_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_out (
        .clk(clk), .rst(rst), .a(i_prod), .b(q_prod), .y(dac_code)
    );

    assign dac_valid = vld_sr[LAT-1];
endmodule

// File: rtl/iq_vecmod_chk.sv
module iq_vecmod_chk (
    input logic               clk,
    input logic               rst,
    input logic signed [15:0] i_word,
    input logic signed [15:0] q_word,
    input logic               in_valid,
    input logic signed [15:0] dac_code,
    input logic               dac_valid
);
    logic [2:0] seen;

    always_ff @(posedge clk) begin
        if (rst)            seen <= '0;
        else if (seen != 4) seen <= seen + 3'd1;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (dac_code == 16'sd0 && !dac_valid));

    // R7
    valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (seen == 3'd4) |-> (dac_valid == $past(in_valid, 4)));

    // R6
    zero_vector_chk: assert property (@(posedge clk) disable iff (rst)
        (seen == 3'd4 && $past(i_word, 4) == 16'sd0 && $past(q_word, 4) == 16'sd0)
        |-> (dac_code == 16'sd0));

    // R5
    no_clamp_small_chk: assert property (@(posedge clk) disable iff (rst)
        (seen == 3'd4
         && $past(i_word, 4) <= 16'sd8191 && $past(i_word, 4) >= -16'sd8191
         && $past(q_word, 4) <= 16'sd8191 && $past(q_word, 4) >= -16'sd8191)
        |-> (dac_code != 16'sh7FFF && dac_code != 16'sh8000));
endmodule

bind iq_vecmod iq_vecmod_chk u_chk (
    .clk(clk), .rst(rst), .i_word(i_word), .q_word(q_word),
    .in_valid(in_valid), .dac_code(dac_code), .dac_valid(dac_valid)
);

// File: tb/iq_vecmod_bench.sv
module iq_vecmod_bench;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic signed [15:0] i_word = '0;
    logic signed [15:0] q_word = '0;
    logic [31:0]        phase_step = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] dac_code;
    logic               dac_valid;

    iq_vecmod u_iq_vecmod (
        .clk(clk), .rst(rst), .i_word(i_word), .q_word(q_word),
        .phase_step(phase_step), .in_valid(in_valid),
        .dac_code(dac_code), .dac_valid(dac_valid)
    );

    always #4 clk = ~clk;   // 125 MHz

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    int          ref_cos [1024];
    int          ref_sin [1024];
    int          exp_code [$];
    bit          exp_vld [$];
    int unsigned m_acc = 0;
    int unsigned seed = 32'h1234_5678;
    string       tag = "R1";

    function automatic int model_out(int iv, int qv, int k);
        longint p;
        longint r;
        p = longint'(iv) * ref_cos[k] + longint'(qv) * ref_sin[k] + 64'sd16384;
        r = p >>> 15;
        if (r > 32767)  r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    function automatic int rnd16();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'($signed(seed[30:15]));
    endfunction

    task automatic check(string req, int act, int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
        end
    endtask

    // one clock: model update at the edge, compare at the falling edge
    task automatic tick();
        @(posedge clk);
        if (rst) begin
            m_acc = 0;
            for (int j = 0; j < 4; j++) begin
                exp_code[j] = 0;
                exp_vld[j]  = 1'b0;
            end
        end else begin
            exp_code.push_front(model_out(int'(i_word), int'(q_word), int'(m_acc >> 22)));
            exp_vld.push_front(in_valid);
            void'(exp_code.pop_back());
            void'(exp_vld.pop_back());
            m_acc = m_acc + phase_step;
        end
        @(negedge clk);
        check(tag, int'(dac_code), exp_code[3]);
        check(tag, int'(dac_valid), int'(exp_vld[3]));
    endtask

    task automatic drive(int iv, int qv, logic [31:0] st, logic v);
        i_word     = 16'(iv);
        q_word     = 16'(qv);
        phase_step = st;
        in_valid   = v;
        tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 1024; k++) begin
            ref_cos[k] = int'(32767.0 * $cos(6.283185307179586 * real'(k) / 1024.0));
            ref_sin[k] = int'(32767.0 * $sin(6.283185307179586 * real'(k) / 1024.0));
        end
        for (int j = 0; j < 4; j++) begin
            exp_code.push_back(0);
            exp_vld.push_back(1'b0);
        end

        // R1: reset state
        tag = "R1";
        rst = 1'b1;
        drive(1000, 2000, 32'h0100_0000, 1'b1);
        drive(1000, 2000, 32'h0100_0000, 1'b1);
        rst = 1'b0;
        drive(0, 0, 0, 1'b0);
        check("R1", int'(dac_code), 0);
        check("R1", int'(dac_valid), 0);

        // R3: cosine table swept one entry per clock, then sine
        tag = "R3";
        for (int n = 0; n < 1030; n++) drive(32767, 0, 32'h0040_0000, 1'b1);
        for (int n = 0; n < 1030; n++) drive(0, 32767, 32'h0040_0000, 1'b1);

        // R2: odd step, sub-index phase carry and wrap
        tag = "R2";
        for (int n = 0; n < 600; n++) drive(20000, -12000, 32'h0123_4567, 1'b1);

        // R4: mixed vectors
        tag = "R4";
        for (int n = 0; n < 2000; n++) drive(rnd16(), rnd16(), 32'h00A0_0003 + 32'(n), 1'b1);

        // R5: clamping at both limits, and small vectors never clamp
        tag = "R5";
        for (int n = 0; n < 300; n++) drive(32767, 32767, 32'h0080_0000, 1'b1);
        for (int n = 0; n < 300; n++) drive(-32768, -32768, 32'h0080_0000, 1'b1);
        for (int n = 0; n < 300; n++) drive(8191, -8191, 32'h0031_0000, 1'b1);

        // R5 with R8: clamp in the same clock as a step change across the wrap
        tag = "R8";
        for (int n = 0; n < 200; n++) drive(32767, 32767, 32'h0200_0000, 1'b1);
        for (int n = 0; n < 200; n++) drive(32767, 32767, 32'hFFC0_0000, 1'b1);
        for (int n = 0; n < 50; n++) begin
            drive(-32768, 32767, 32'h7FFF_FFFF, 1'b1);
            drive(-32768, 32767, 32'h0000_0001, 1'b1);
        end

        // R6: zero vector at every phase, valid toggling
        tag = "R6";
        for (int n = 0; n < 1100; n++) drive(0, 0, 32'h003F_1234, 1'(n % 3 == 0));

        // R7: valid pattern with changing data
        tag = "R7";
        for (int n = 0; n < 400; n++) drive(rnd16(), rnd16(), 32'h0111_0000, 1'(rnd16() > 0));

        // R1: reset mid-stream
        tag = "R1";
        rst = 1'b1;
        drive(5000, 5000, 32'h0100_0000, 1'b1);
        rst = 1'b0;
        drive(5000, 5000, 32'h0100_0000, 1'b1);
        check("R1", int'(dac_valid), 0);
        for (int n = 0; n < 20; n++) drive(5000, 5000, 32'h0100_0000, 1'b1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule